// File: doc/BRIEF.md
# Interrupt Redirection and Capture Unit

The unit watches a set of asynchronous interrupt lines and turns each request into a delivery message. Every line owns a 64-bit redirection entry that software programs through a simple word-wide configuration port: an 8-bit vector, an active-low select, an edge/level select, a mask, a destination addressing mode and an 8-bit destination. Each line is synchronized, its polarity applied, and a request is captured into a per-line delivery-status bit. For an edge request, the active level must be held for two or more sampled clocks. For a level request, the line is sampled while it is active.

A round-robin scanner picks one pending, unmasked line at a time and presents its vector, destination, destination mode and trigger mode on a valid/accept handshake. The physical line index sets only the scan order. The priority a receiver gives the interrupt comes from the programmed vector. A line's delivery-status bit blocks new requests from that line until its message is accepted. A level-triggered line then waits on its remote-pending bit, which an end-of-interrupt pulse carrying a matching vector clears.

Top module: `irq_redirect`

## Requirements
- R1: After reset, every entry reads back with only the mask set (low word 0x0001_0000, high word 0) and `msg_valid_o` is low.
- R2: Low-word field positions are vector [7:0], destination mode 11, delivery status 12, active-low select 13, remote pending 14, level select 15 and mask 16. The destination sits in high-word bits [31:24]. Bits 12 and 14 ignore writes. Every other bit reads 0, and so does any index at or above the line count.
- R3: An edge line is captured when its active level is seen on two consecutive synchronized samples. An active level that lasts one clock is ignored.
- R4: With bit 13 set, a line is active when low. With bit 13 clear, it is active when high.
- R5: While a line's delivery status is set, further edges on that line are ignored. The status clears only when that line's message is accepted.
- R6: A masked line sets no delivery status and produces no message.
- R7: Accepting a level-mode message sets that line's remote-pending bit. No new message comes from that line while the bit is set. An end-of-interrupt pulse whose vector matches clears the bit, and a mismatching vector leaves it set. If the line is still active after the clear, a new message follows.
- R8: Pending lines are served in round-robin index order. The scan starts one index after the last accepted line, and the vector value has no effect on the order.
- R9: One message is outstanding at a time. `msg_valid_o` and all message fields hold steady until `msg_ready_i` is seen high.
- R10: In physical mode (bit 11 = 0), the message destination is entry bits [59:56] zero-extended to 8 bits. In logical mode, it is the full 8 bits [63:56].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 24 | Asynchronous interrupt lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 5 | Entry index |
| cfg_hi_i | input | 1 | Word select: 0 = bits 31:0, 1 = bits 63:32 |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the selected word (combinational) |
| eoi_i | input | 1 | End-of-interrupt pulse |
| eoi_vec_i | input | 8 | Vector carried with the end-of-interrupt pulse |
| msg_valid_o | output | 1 | Message present |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_vector_o | output | 8 | Message vector |
| msg_dest_o | output | 8 | Message destination |
| msg_dest_mode_o | output | 1 | 0 = physical, 1 = logical |
| msg_level_o | output | 1 | 1 = level-triggered source |

## Verification
The hardest state to reach from the ports is a level-mode line stuck behind its remote-pending bit while its input stays active. To get there, the bench holds the line active through an accept. It then shows that no message appears and that a mismatching end-of-interrupt changes nothing. Only then does it send the matching vector and expect a fresh message. Round-robin rotation is reached by first steering the scan pointer with a known sequence of accepted lines, then raising lines on both sides of it in the same cycle.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned DEST_W    = 8;
  localparam int unsigned WORD_W    = 32;
  // low-word bit positions
  localparam int unsigned DMODE_BIT = 11;
  localparam int unsigned DS_BIT    = 12;
  localparam int unsigned POL_BIT   = 13;
  localparam int unsigned RIRR_BIT  = 14;
  localparam int unsigned TRIG_BIT  = 15;
  localparam int unsigned MASK_BIT  = 16;
  // high-word destination lsb
  localparam int unsigned DEST_LSB  = 24;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;   // 1 = level
    logic              pol;    // 1 = active low
    logic              dmode;  // 1 = logical
    logic [VEC_W-1:0]  vector;
  } redir_entry_t;

  function automatic redir_entry_t entry_rst();
    redir_entry_t e;
    e      = '0;
    e.mask = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/irq_in_cond.sv
module irq_in_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic pol_i,
  output logic act_o,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic act_d1_q, act_d2_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= irq_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], irq_i};
      end
    end
  endgenerate

  assign act_o = sync_q[SYNC_STAGES-1] ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_d1_q <= 1'b0;
      act_d2_q <= 1'b0;
    end else begin
      act_d1_q <= act_o;
      act_d2_q <= act_d1_q;
    end
  end

  // active on two consecutive samples after an inactive one
  assign edge_o = act_o & act_d1_q & ~act_d2_q;
endmodule

// File: rtl/redir_table.sv
module redir_table
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_IRQ = 24,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [IDX_W-1:0]         cfg_idx_i,
  input  logic                     cfg_hi_i,
  input  logic [WORD_W-1:0]        cfg_wdata_i,
  output logic [WORD_W-1:0]        cfg_rdata_o,
  input  logic [N_IRQ-1:0]         act_i,
  input  logic [N_IRQ-1:0]         edge_i,
  input  logic                     acc_i,
  input  logic [IDX_W-1:0]         acc_idx_i,
  input  logic                     acc_level_i,
  input  logic                     eoi_i,
  input  logic [VEC_W-1:0]         eoi_vec_i,
  output redir_entry_t [N_IRQ-1:0] entries_o,
  output logic [N_IRQ-1:0]         ds_o,
  output logic [N_IRQ-1:0]         rirr_o
);
  redir_entry_t [N_IRQ-1:0] ent_q;
  logic [N_IRQ-1:0] ds_q, rirr_q, set_req;
  logic idx_ok;

  assign idx_ok = {1'b0, cfg_idx_i} < (IDX_W+1)'(N_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_IRQ); i++) ent_q[i] <= entry_rst();
    end else if (cfg_we_i && idx_ok) begin
      if (cfg_hi_i) begin
        ent_q[cfg_idx_i].dest <= cfg_wdata_i[DEST_LSB +: DEST_W];
      end else begin
        ent_q[cfg_idx_i].vector <= cfg_wdata_i[VEC_W-1:0];
        ent_q[cfg_idx_i].dmode  <= cfg_wdata_i[DMODE_BIT];
        ent_q[cfg_idx_i].pol    <= cfg_wdata_i[POL_BIT];
        ent_q[cfg_idx_i].trig   <= cfg_wdata_i[TRIG_BIT];
        ent_q[cfg_idx_i].mask   <= cfg_wdata_i[MASK_BIT];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < int'(N_IRQ); i++) begin
      set_req[i] = ~ds_q[i] & ~ent_q[i].mask &
                   (ent_q[i].trig ? (act_i[i] & ~rirr_q[i]) : edge_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ds_q   <= '0;
      rirr_q <= '0;
    end else begin
      for (int i = 0; i < int'(N_IRQ); i++) begin
        if (acc_i && acc_idx_i == IDX_W'(i))  ds_q[i] <= 1'b0;
        else if (set_req[i])                   ds_q[i] <= 1'b1;

        if (acc_i && acc_idx_i == IDX_W'(i) && acc_level_i)
          rirr_q[i] <= 1'b1;
        else if (eoi_i && eoi_vec_i == ent_q[i].vector)
          rirr_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (idx_ok) begin
      if (cfg_hi_i) begin
        cfg_rdata_o[DEST_LSB +: DEST_W] = ent_q[cfg_idx_i].dest;
      end else begin
        cfg_rdata_o[VEC_W-1:0] = ent_q[cfg_idx_i].vector;
        cfg_rdata_o[DMODE_BIT] = ent_q[cfg_idx_i].dmode;
        cfg_rdata_o[DS_BIT]    = ds_q[cfg_idx_i];
        cfg_rdata_o[POL_BIT]   = ent_q[cfg_idx_i].pol;
        cfg_rdata_o[RIRR_BIT]  = rirr_q[cfg_idx_i];
        cfg_rdata_o[TRIG_BIT]  = ent_q[cfg_idx_i].trig;
        cfg_rdata_o[MASK_BIT]  = ent_q[cfg_idx_i].mask;
      end
    end
  end

  assign entries_o = ent_q;
  assign ds_o      = ds_q;
  assign rirr_o    = rirr_q;
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N = 24,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    int j;
    any_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < int'(N); k++) begin
      j = int'(ptr_i) + k;
      if (j >= int'(N)) j = j - int'(N);
      if (!any_o && req_i[j]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_IRQ       = 24,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_hi_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              eoi_i,
  input  logic [7:0]        eoi_vec_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [7:0]        msg_vector_o,
  output logic [7:0]        msg_dest_o,
  output logic              msg_dest_mode_o,
  output logic              msg_level_o
);
  redir_entry_t [N_IRQ-1:0] entries;
  logic [N_IRQ-1:0] act, edg, ds_q, rirr_q, eligible;
  logic [IDX_W-1:0] rr_ptr_q, cur_q, pick_idx;
  logic             busy_q, pick_any, accept;

  generate
    for (genvar g = 0; g < int'(N_IRQ); g++) begin : g_in
      irq_in_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .irq_i  (irq_i[g]),
        .pol_i  (entries[g].pol),
        .act_o  (act[g]),
        .edge_o (edg[g])
      );
    end
  endgenerate

  assign accept = busy_q & msg_ready_i;

  redir_table #(.N_IRQ(N_IRQ)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_hi_i    (cfg_hi_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .act_i       (act),
    .edge_i      (edg),
    .acc_i       (accept),
    .acc_idx_i   (cur_q),
    .acc_level_i (msg_level_o),
    .eoi_i       (eoi_i),
    .eoi_vec_i   (eoi_vec_i),
    .entries_o   (entries),
    .ds_o        (ds_q),
    .rirr_o      (rirr_q)
  );

  always_comb begin
    for (int i = 0; i < int'(N_IRQ); i++) eligible[i] = ds_q[i] & ~entries[i].mask;
  end

  rr_pick #(.N(N_IRQ)) u_pick (
    .req_i (eligible),
    .ptr_i (rr_ptr_q),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q          <= 1'b0;
      cur_q           <= '0;
      rr_ptr_q        <= '0;
      msg_vector_o    <= '0;
      msg_dest_o      <= '0;
      msg_dest_mode_o <= 1'b0;
      msg_level_o     <= 1'b0;
    end else if (accept) begin
      busy_q   <= 1'b0;
      rr_ptr_q <= (cur_q == IDX_W'(N_IRQ-1)) ? '0 : cur_q + 1'b1;
    end else if (!busy_q && pick_any) begin
      busy_q          <= 1'b1;
      cur_q           <= pick_idx;
      msg_vector_o    <= entries[pick_idx].vector;
      msg_dest_mode_o <= entries[pick_idx].dmode;
      msg_level_o     <= entries[pick_idx].trig;
      msg_dest_o      <= entries[pick_idx].dmode ? entries[pick_idx].dest
                                                 : {4'b0, entries[pick_idx].dest[3:0]};
    end
  end

  assign msg_valid_o = busy_q;
endmodule

// File: rtl/irq_redirect_chk.sv
module irq_redirect_chk #(
  parameter int unsigned N_IRQ = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msg_valid_i,
  input logic             msg_ready_i,
  input logic [7:0]       msg_vector_i,
  input logic [7:0]       msg_dest_i,
  input logic             msg_dest_mode_i,
  input logic             msg_level_i,
  input logic [N_IRQ-1:0] ds_i,
  input logic [N_IRQ-1:0] rirr_i
);
  a_r9_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && !msg_ready_i |=> msg_valid_i);

  a_r9_fields_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && !msg_ready_i |=> $stable(msg_vector_i) && $stable(msg_dest_i)
      && $stable(msg_dest_mode_i) && $stable(msg_level_i));

  a_r10_phys_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && !msg_dest_mode_i |-> msg_dest_i[7:4] == 4'h0);

  a_r5_ds_clear_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |($past(ds_i) & ~ds_i) |-> $past(msg_valid_i && msg_ready_i)
      && $countones($past(ds_i) & ~ds_i) == 1);

  a_r7_rirr_on_level_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rirr_i & ~$past(rirr_i)) |-> $past(msg_valid_i && msg_ready_i && msg_level_i));

  a_r9_valid_has_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i |-> |ds_i);
endmodule

bind irq_redirect irq_redirect_chk #(.N_IRQ(N_IRQ)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .msg_valid_i     (msg_valid_o),
  .msg_ready_i     (msg_ready_i),
  .msg_vector_i    (msg_vector_o),
  .msg_dest_i      (msg_dest_o),
  .msg_dest_mode_i (msg_dest_mode_o),
  .msg_level_i     (msg_level_o),
  .ds_i            (ds_q),
  .rirr_i          (rirr_q)
);

// File: tb/irq_redirect_tb_top.sv
module irq_redirect_tb_top;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        we = 1'b0, hi = 1'b0, eoi = 1'b0, rdy = 1'b0;
  logic [4:0]  idx = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  eoi_vec = '0, vec, dest;
  logic        valid, dmode, level;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_redirect dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .cfg_we_i(we), .cfg_idx_i(idx), .cfg_hi_i(hi), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .eoi_i(eoi), .eoi_vec_i(eoi_vec),
    .msg_valid_o(valid), .msg_ready_i(rdy), .msg_vector_o(vec),
    .msg_dest_o(dest), .msg_dest_mode_o(dmode), .msg_level_o(level)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int i, input bit h, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; idx = 5'(i); hi = h; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int i, input bit h, output logic [31:0] d);
    @(negedge clk);
    idx = 5'(i); hi = h;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m, input int n);
    @(negedge clk);
    irq = irq ^ m;
    cyc(n);
    irq = irq ^ m;
  endtask

  task automatic wait_msg(output bit got);
    got = 1'b0;
    for (int k = 0; k < 20 && !got; k++) begin
      @(negedge clk);
      got = valid;
    end
  endtask

  task automatic take();
    @(negedge clk);
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi = 1'b1; eoi_vec = v;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(valid == 1'b0, "R1 valid after reset", 32'(valid), 0);
    rd(0, 0, d);  chk(d == 32'h0001_0000, "R1 entry0 low", d, 32'h0001_0000);
    rd(0, 1, d);  chk(d == 32'h0, "R1 entry0 high", d, 0);
    rd(23, 0, d); chk(d == 32'h0001_0000, "R1 entry23 low", d, 32'h0001_0000);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(5, 0, 32'hFFFF_FFFF);
    rd(5, 0, d); chk(d == 32'h0001_A8FF, "R2 low fields, ds/rirr ignored", d, 32'h0001_A8FF);
    wr(5, 1, 32'hFFFF_FFFF);
    rd(5, 1, d); chk(d == 32'hFF00_0000, "R2 high field", d, 32'hFF00_0000);
    wr(30, 0, 32'h0000_00AA);
    rd(30, 0, d); chk(d == 32'h0, "R2 out-of-range index", d, 0);
    wr(5, 0, 32'h0001_0000);
    wr(5, 1, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    bit got;
    wr(2, 0, 32'h0000_0041);
    wr(2, 1, 32'h3A00_0000);
    pulse(24'h4, 1);
    cyc(10);
    chk(valid == 1'b0, "R3 one-clock pulse ignored", 32'(valid), 0);
    rd(2, 0, d); chk(d[12] == 1'b0, "R3 ds after short pulse", 32'(d[12]), 0);
    pulse(24'h4, 3);
    wait_msg(got);
    chk(got, "R3 edge message", 32'(got), 1);
    chk(vec == 8'h41, "R3 vector", 32'(vec), 32'h41);
    chk(dest == 8'h0A && dmode == 1'b0, "R10 physical dest", 32'({dmode, dest}), 32'h0A);
    chk(level == 1'b0, "R3 edge trigger flag", 32'(level), 0);
    rd(2, 0, d); chk(d[12] == 1'b1, "R5 ds set while pending", 32'(d[12]), 1);
    pulse(24'h4, 3);
    cyc(5);
    chk(valid && vec == 8'h41, "R9 held until accept", 32'({valid, vec}), 32'h141);
    take();
    cyc(1);
    chk(valid == 1'b0, "R9 valid drops after accept", 32'(valid), 0);
    cyc(10);
    chk(valid == 1'b0, "R5 edge during pending ignored", 32'(valid), 0);
    rd(2, 0, d); chk(d[12] == 1'b0, "R5 ds cleared by accept", 32'(d[12]), 0);
  endtask

  task automatic t_logical();
    bit got;
    wr(3, 0, 32'h0000_0833);
    wr(3, 1, 32'h3A00_0000);
    pulse(24'h8, 3);
    wait_msg(got);
    chk(got && vec == 8'h33, "R10 logical message", 32'(vec), 32'h33);
    chk(dest == 8'h3A && dmode == 1'b1, "R10 logical dest", 32'({dmode, dest}), 32'h13A);
    take();
  endtask

  task automatic t_polarity();
    bit got;
    irq[4] = 1'b1;
    cyc(5);
    wr(4, 0, 32'h0000_2052);
    cyc(10);
    chk(valid == 1'b0, "R4 high is idle when active low", 32'(valid), 0);
    pulse(24'h10, 3);
    wait_msg(got);
    chk(got && vec == 8'h52, "R4 active-low edge", 32'(vec), 32'h52);
    take();
    irq[4] = 1'b0;
    wr(4, 0, 32'h0001_0000);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(6, 0, 32'h0001_0060);
    pulse(24'h40, 3);
    cyc(10);
    chk(valid == 1'b0, "R6 masked no message", 32'(valid), 0);
    rd(6, 0, d); chk(d[12] == 1'b0, "R6 masked ds clear", 32'(d[12]), 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    bit got;
    wr(7, 0, 32'h0000_8070);
    irq[7] = 1'b1;
    wait_msg(got);
    chk(got && vec == 8'h70 && level, "R7 level message", 32'({level, vec}), 32'h170);
    take();
    rd(7, 0, d); chk(d[14] == 1'b1, "R7 rirr set on accept", 32'(d[14]), 1);
    cyc(10);
    chk(valid == 1'b0, "R7 blocked by rirr", 32'(valid), 0);
    send_eoi(8'h71);
    cyc(10);
    rd(7, 0, d);
    chk(valid == 1'b0 && d[14], "R7 mismatched eoi no effect", 32'({valid, d[14]}), 1);
    send_eoi(8'h70);
    wait_msg(got);
    chk(got && vec == 8'h70, "R7 re-request after eoi", 32'(vec), 32'h70);
    take();
    irq[7] = 1'b0;
    cyc(5);
    send_eoi(8'h70);
    cyc(10);
    rd(7, 0, d);
    chk(valid == 1'b0 && !d[14], "R7 inactive line after eoi", 32'({valid, d[14]}), 0);
  endtask

  task automatic t_rr();
    bit got;
    logic [7:0] exp1 [3] = '{8'h20, 8'h90, 8'h30};
    logic [7:0] exp2 [2] = '{8'h10, 8'h20};
    wr(8, 0, 32'h0000_0020);
    wr(9, 0, 32'h0000_0090);
    wr(10, 0, 32'h0000_0030);
    wr(12, 0, 32'h0000_0010);
    pulse(24'h000700, 3);
    for (int k = 0; k < 3; k++) begin
      wait_msg(got);
      chk(got && vec == exp1[k], "R8 index order", 32'(vec), 32'(exp1[k]));
      take();
    end
    pulse(24'h001100, 3);
    for (int k = 0; k < 2; k++) begin
      wait_msg(got);
      chk(got && vec == exp2[k], "R8 rotation after pointer", 32'(vec), 32'(exp2[k]));
      take();
    end
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_regs();
    t_edge();
    t_logical();
    t_polarity();
    t_mask();
    t_level();
    t_rr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule